// File: doc/BRIEF.md
# Serial IRQ Host Interrupt Encoder

This block carries the interrupt requests of three peripheral mailbox channels to a host over one shared, wired-low serial interrupt line. It runs on the host-bus clock. The host opens each frame with a start pulse. A fixed run of three-clock slots follows, and the host ends the frame with a stop pulse. The encoder pulls the line low in the first clock of each slot whose request is active. It drives the line high for one clock after that to restore it quickly. In every other clock it leaves the line to the pull-up.

Channel 1 can raise IRQ1 and IRQ12. Channels 2 and 3 each offer five requests (SMI, IRQ6, IRQ9, IRQ10, IRQ11), and the two channels share slots. In continuous mode the encoder waits for the host to open every frame. In quiet mode the encoder itself may pull the line low for one clock while the line is idle, which asks the host for a frame. It does so when its request picture differs from the one it last showed. The slot positions, the start pulse length and the two stop lengths are parameters.

Top module: `sirq_host_encoder`

## Requirements
- R1: While reset is asserted and after reset is released, with no frame running, `sirq_oe` is 0.
- R2: `ch1_irq[0]` is shown in slot 1 (IRQ1) and `ch1_irq[1]` is shown in slot 12 (IRQ12). Slots are numbered from 0 for the first slot after the start frame.
- R3: Bits 0..4 of `ch2_irq` and `ch3_irq` map to slots 2 (SMI), 6, 9, 10 and 11, in that order. The two channels are ORed per slot, and no other slot is ever driven.
- R4: Each slot lasts three clocks: sample, recovery and turnaround. For an active slot, `sirq_oe`=1 with `sirq_out`=0 in sample and `sirq_oe`=1 with `sirq_out`=1 in recovery. In turnaround, and throughout an inactive slot, `sirq_oe`=0.
- R5: A frame opens when the idle line is seen low for at least 4 clocks and then high. The clock after that high clock is a turnaround, and slot 0's sample clock comes one clock later. There are 17 slots.
- R6: With `quiet_mode`=0 the encoder never drives the line outside the slots, whatever its requests.
- R7: With `quiet_mode`=1, while idle, with the line high and no low run in progress, the encoder drives low for exactly one clock if its mapped request vector differs from the values it showed in the last frame. This covers both newly set and newly cleared requests.
- R8: With `quiet_mode`=1 and requests unchanged since they were last shown, the idle encoder does not drive the line.
- R9: After the last slot the encoder returns to idle only after the line has been low for at least 2 clocks (quiet) or 3 clocks (continuous) and then high. A shorter stop is not accepted, and a start pulse that follows it opens no frame.
- R10: An idle low run shorter than 4 clocks opens no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host-bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| quiet_mode | input | 1 | 1 = quiet mode (the encoder may request frames), 0 = continuous mode |
| ch1_irq | input | 2 | Channel 1 requests: bit 0 IRQ1, bit 1 IRQ12 |
| ch2_irq | input | 5 | Channel 2 requests: SMI, IRQ6, IRQ9, IRQ10, IRQ11 in bits 0..4 |
| ch3_irq | input | 5 | Channel 3 requests, same layout as channel 2 |
| sirq_in | input | 1 | Resolved level of the shared serial interrupt line |
| sirq_oe | output | 1 | Line drive enable |
| sirq_out | output | 1 | Level driven while `sirq_oe` is 1 |

## Verification
The properties take for granted that the host never pulls the line low during a slot. Only the start and stop pulses come from the host. They also take for granted that `quiet_mode` changes only while the encoder is idle and has no unshown request. The bench's host model keeps its pull-down released for the whole slot window and toggles the mode only between frames, after a clearing frame. The line is modelled as the wired-low combination of host and encoder with a pull-up, so the encoder's own request pulse counts toward the start pulse, as it does on a real line.

// File: rtl/sirq_enc_pkg.sv
package sirq_enc_pkg;

  localparam int CH1_REQS  = 2;
  localparam int CH23_REQS = 5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_START_TA,
    ST_SLOT,
    ST_STOP
  } sirq_state_e;

  typedef enum logic [1:0] {
    PH_SAMPLE,
    PH_RECOV,
    PH_TURN
  } sirq_phase_e;

endpackage

// File: rtl/sirq_req_map.sv
module sirq_req_map
  import sirq_enc_pkg::*;
#(
  parameter int NUM_SLOTS  = 17,
  parameter int SLOT_IRQ1  = 1,
  parameter int SLOT_IRQ12 = 12,
  parameter int SLOT_SMI   = 2,
  parameter int SLOT_IRQ6  = 6,
  parameter int SLOT_IRQ9  = 9,
  parameter int SLOT_IRQ10 = 10,
  parameter int SLOT_IRQ11 = 11
) (
  input  logic [CH1_REQS-1:0]  ch1_req,
  input  logic [CH23_REQS-1:0] ch2_req,
  input  logic [CH23_REQS-1:0] ch3_req,
  output logic [NUM_SLOTS-1:0] slot_vec
);

  localparam int CH1_SLOT  [CH1_REQS]  = '{SLOT_IRQ1, SLOT_IRQ12};
  localparam int CH23_SLOT [CH23_REQS] = '{SLOT_SMI, SLOT_IRQ6, SLOT_IRQ9,
                                           SLOT_IRQ10, SLOT_IRQ11};

  // channels 2 and 3 share every slot they can raise
  logic [CH23_REQS-1:0] ch23_any;
  assign ch23_any = ch2_req | ch3_req;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic [CH1_REQS-1:0]  hit1;
    logic [CH23_REQS-1:0] hit23;
    for (genvar k = 0; k < CH1_REQS; k++) begin : g_c1
      assign hit1[k] = (CH1_SLOT[k] == s) && ch1_req[k];
    end
    for (genvar k = 0; k < CH23_REQS; k++) begin : g_c23
      assign hit23[k] = (CH23_SLOT[k] == s) && ch23_any[k];
    end
    assign slot_vec[s] = (|hit1) | (|hit23);
  end

endmodule

// File: rtl/sirq_frame_fsm.sv
module sirq_frame_fsm
  import sirq_enc_pkg::*;
#(
  parameter int NUM_SLOTS  = 17,
  parameter int START_MIN  = 4,
  parameter int STOP_QUIET = 2,
  parameter int STOP_CONT  = 3,
  localparam int SLOT_W    = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_in,
  input  logic              quiet_mode,
  input  logic              start_req,
  output sirq_state_e       st,
  output sirq_phase_e       ph,
  output logic [SLOT_W-1:0] slot
);

  localparam int CNT_MAX = (START_MIN > STOP_CONT) ?
                           ((START_MIN > STOP_QUIET) ? START_MIN : STOP_QUIET) :
                           ((STOP_CONT > STOP_QUIET) ? STOP_CONT : STOP_QUIET);
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0]  CNT_TOP   = CNT_W'(CNT_MAX);
  localparam logic [CNT_W-1:0]  START_LEN = CNT_W'(START_MIN);
  localparam logic [CNT_W-1:0]  STOP_Q    = CNT_W'(STOP_QUIET);
  localparam logic [CNT_W-1:0]  STOP_C    = CNT_W'(STOP_CONT);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);

  sirq_state_e       st_q, st_d;
  sirq_phase_e       ph_q, ph_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [CNT_W-1:0]  cnt_inc;
  logic [CNT_W-1:0]  stop_len;

  assign cnt_inc  = (cnt_q == CNT_TOP) ? cnt_q : cnt_q + 1'b1;
  assign stop_len = quiet_mode ? STOP_Q : STOP_C;

  always_comb begin
    st_d   = st_q;
    ph_d   = ph_q;
    slot_d = slot_q;
    cnt_d  = cnt_q;
    unique case (st_q)
      ST_IDLE: begin
        if (!line_in) begin
          cnt_d = cnt_inc;
        end else begin
          cnt_d = '0;
          if (cnt_q >= START_LEN) begin
            st_d = ST_START_TA;
          end else if (start_req && (cnt_q == '0)) begin
            st_d = ST_REQ;
          end
        end
      end
      ST_REQ: begin
        st_d  = ST_IDLE;
        cnt_d = line_in ? '0 : cnt_inc;
      end
      ST_START_TA: begin
        st_d   = ST_SLOT;
        ph_d   = PH_SAMPLE;
        slot_d = '0;
      end
      ST_SLOT: begin
        unique case (ph_q)
          PH_SAMPLE: ph_d = PH_RECOV;
          PH_RECOV:  ph_d = PH_TURN;
          default: begin
            ph_d = PH_SAMPLE;
            if (slot_q == LAST_SLOT) begin
              st_d  = ST_STOP;
              cnt_d = '0;
            end else begin
              slot_d = slot_q + 1'b1;
            end
          end
        endcase
      end
      ST_STOP: begin
        if (!line_in) begin
          cnt_d = cnt_inc;
        end else begin
          cnt_d = '0;
          if (cnt_q >= stop_len) st_d = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      ph_q   <= PH_SAMPLE;
      slot_q <= '0;
      cnt_q  <= '0;
    end else begin
      st_q   <= st_d;
      ph_q   <= ph_d;
      slot_q <= slot_d;
      cnt_q  <= cnt_d;
    end
  end

  assign st   = st_q;
  assign ph   = ph_q;
  assign slot = slot_q;

endmodule

// File: rtl/sirq_host_encoder.sv
module sirq_host_encoder
  import sirq_enc_pkg::*;
#(
  parameter int NUM_SLOTS  = 17,
  parameter int START_MIN  = 4,
  parameter int STOP_QUIET = 2,
  parameter int STOP_CONT  = 3,
  parameter int SLOT_IRQ1  = 1,
  parameter int SLOT_IRQ12 = 12,
  parameter int SLOT_SMI   = 2,
  parameter int SLOT_IRQ6  = 6,
  parameter int SLOT_IRQ9  = 9,
  parameter int SLOT_IRQ10 = 10,
  parameter int SLOT_IRQ11 = 11
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       quiet_mode,
  input  logic [1:0] ch1_irq,
  input  logic [4:0] ch2_irq,
  input  logic [4:0] ch3_irq,
  input  logic       sirq_in,
  output logic       sirq_oe,
  output logic       sirq_out
);

  localparam int SLOT_W = $clog2(NUM_SLOTS);

  // reset: asserted at once, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [NUM_SLOTS-1:0] slot_vec;
  logic [NUM_SLOTS-1:0] shown_q, shown_d;
  logic                 drove_q, drove_d;
  logic                 start_req;
  logic                 in_sample, in_recov;
  logic                 cur_bit;
  sirq_state_e          fsm_st;
  sirq_phase_e          fsm_ph;
  logic [SLOT_W-1:0]    fsm_slot;

  sirq_req_map #(
    .NUM_SLOTS (NUM_SLOTS),
    .SLOT_IRQ1 (SLOT_IRQ1),
    .SLOT_IRQ12(SLOT_IRQ12),
    .SLOT_SMI  (SLOT_SMI),
    .SLOT_IRQ6 (SLOT_IRQ6),
    .SLOT_IRQ9 (SLOT_IRQ9),
    .SLOT_IRQ10(SLOT_IRQ10),
    .SLOT_IRQ11(SLOT_IRQ11)
  ) u_map (
    .ch1_req (ch1_irq),
    .ch2_req (ch2_irq),
    .ch3_req (ch3_irq),
    .slot_vec(slot_vec)
  );

  sirq_frame_fsm #(
    .NUM_SLOTS (NUM_SLOTS),
    .START_MIN (START_MIN),
    .STOP_QUIET(STOP_QUIET),
    .STOP_CONT (STOP_CONT)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .line_in   (sirq_in),
    .quiet_mode(quiet_mode),
    .start_req (start_req),
    .st        (fsm_st),
    .ph        (fsm_ph),
    .slot      (fsm_slot)
  );

  assign in_sample = (fsm_st == ST_SLOT) && (fsm_ph == PH_SAMPLE);
  assign in_recov  = (fsm_st == ST_SLOT) && (fsm_ph == PH_RECOV);
  assign cur_bit   = slot_vec[fsm_slot];
  assign start_req = quiet_mode && (slot_vec != shown_q);

  always_comb begin
    shown_d = shown_q;
    drove_d = drove_q;
    if (in_sample) begin
      shown_d[fsm_slot] = cur_bit;
      drove_d           = cur_bit;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      shown_q <= '0;
      drove_q <= 1'b0;
    end else begin
      shown_q <= shown_d;
      drove_q <= drove_d;
    end
  end

  assign sirq_oe  = (in_sample && cur_bit) || (in_recov && drove_q) ||
                    (fsm_st == ST_REQ);
  assign sirq_out = in_recov && drove_q;

endmodule

// File: rtl/sirq_host_encoder_chk.sv
module sirq_host_encoder_chk
  import sirq_enc_pkg::*;
#(
  parameter int NUM_SLOTS = 17,
  parameter int SLOT_IRQ1 = 1,
  parameter int SLOT_SMI  = 2,
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              quiet_mode,
  input logic [1:0]        ch1_irq,
  input logic [4:0]        ch2_irq,
  input logic [4:0]        ch3_irq,
  input logic              sirq_oe,
  input logic              sirq_out,
  input sirq_state_e       st,
  input sirq_phase_e       ph,
  input logic [SLOT_W-1:0] slot
);

  a_r4_low_only_sample: assert property (@(posedge clk) disable iff (!rst_n)
    (sirq_oe && !sirq_out) |-> ((st == ST_SLOT && ph == PH_SAMPLE) || st == ST_REQ));

  a_r4_high_after_low: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SLOT && ph == PH_SAMPLE && sirq_oe) |=> (sirq_oe && sirq_out));

  a_r4_turn_released: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SLOT && ph == PH_TURN) |-> !sirq_oe);

  a_r4_recov_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SLOT && ph == PH_RECOV && !$past(sirq_oe)) |-> !sirq_oe);

  a_r2_irq1_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SLOT && ph == PH_SAMPLE && slot == SLOT_W'(SLOT_IRQ1) && ch1_irq[0])
      |-> (sirq_oe && !sirq_out));

  a_r3_smi_or: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SLOT && ph == PH_SAMPLE && slot == SLOT_W'(SLOT_SMI) &&
     (ch2_irq[0] || ch3_irq[0])) |-> (sirq_oe && !sirq_out));

  a_r5_slot0_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_START_TA) |=> (st == ST_SLOT && ph == PH_SAMPLE && slot == '0));

  a_r6_cont_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (!quiet_mode && st != ST_SLOT) |-> !sirq_oe);

  a_r7_req_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_REQ) |=> (st != ST_REQ));

endmodule

bind sirq_host_encoder sirq_host_encoder_chk #(
  .NUM_SLOTS(NUM_SLOTS),
  .SLOT_IRQ1(SLOT_IRQ1),
  .SLOT_SMI (SLOT_SMI)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .quiet_mode(quiet_mode),
  .ch1_irq   (ch1_irq),
  .ch2_irq   (ch2_irq),
  .ch3_irq   (ch3_irq),
  .sirq_oe   (sirq_oe),
  .sirq_out  (sirq_out),
  .st        (fsm_st),
  .ph        (fsm_ph),
  .slot      (fsm_slot)
);

// File: tb/sirq_host_encoder_bench.sv
`timescale 1ns/1ps
module sirq_host_encoder_bench;

  logic       clk;
  logic       rst_n;
  logic       quiet_mode;
  logic [1:0] ch1_irq;
  logic [4:0] ch2_irq;
  logic [4:0] ch3_irq;
  logic       host_low;
  logic       sirq_line;
  logic       sirq_oe;
  logic       sirq_out;

  int total = 0;
  int bad   = 0;

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // wired-low line with pull-up
  assign sirq_line = host_low ? 1'b0 : (sirq_oe ? sirq_out : 1'b1);

  sirq_host_encoder u_sirq_host_encoder (
    .clk       (clk),
    .rst_n     (rst_n),
    .quiet_mode(quiet_mode),
    .ch1_irq   (ch1_irq),
    .ch2_irq   (ch2_irq),
    .ch3_irq   (ch3_irq),
    .sirq_in   (sirq_line),
    .sirq_oe   (sirq_oe),
    .sirq_out  (sirq_out)
  );

  // {ch1, ch2, ch3, expected slot mask (bit n = slot n pulled low)}
  localparam int NV = 7;
  localparam logic [28:0] VEC [NV] = '{
    {2'b00, 5'b00000, 5'b00000, 17'h00000},
    {2'b01, 5'b00000, 5'b00000, 17'h00002},
    {2'b10, 5'b00000, 5'b00000, 17'h01000},
    {2'b00, 5'b00001, 5'b00000, 17'h00004},
    {2'b00, 5'b00000, 5'b11110, 17'h00E40},
    {2'b00, 5'b10100, 5'b00110, 17'h00A40},
    {2'b11, 5'b11111, 5'b11111, 17'h01E46}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // host start pulse, 17 slots observed, host stop pulse of stop_lows clocks
  task automatic run_frame(input int stop_lows, output logic [16:0] mask,
                           output bit proto_ok);
    logic lowed;
    mask     = '0;
    proto_ok = 1'b1;
    lowed    = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); host_low = 1'b1;
    end
    @(negedge clk); host_low = 1'b0;
    @(negedge clk);
    for (int s = 0; s < 17; s++) begin
      for (int p = 0; p < 3; p++) begin
        @(negedge clk); #1;
        if (p == 0) begin
          lowed   = sirq_oe && !sirq_out;
          mask[s] = lowed;
          if (sirq_oe && sirq_out) proto_ok = 1'b0;
        end else if (p == 1) begin
          if (lowed && !(sirq_oe && sirq_out)) proto_ok = 1'b0;
          if (!lowed && sirq_oe) proto_ok = 1'b0;
        end else begin
          if (sirq_oe) proto_ok = 1'b0;
        end
      end
    end
    for (int i = 0; i < stop_lows; i++) begin
      @(negedge clk); host_low = 1'b1;
    end
    @(negedge clk); host_low = 1'b0;
    @(negedge clk);
  endtask

  task automatic watch(input int n, output bit seen);
    seen = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      if (sirq_oe) seen = 1'b1;
    end
  endtask

  initial begin
    #600000;
    total++;
    bad++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [16:0] mask;
    bit          pok;
    bit          seen;

    rst_n      = 1'b0;
    quiet_mode = 1'b0;
    ch1_irq    = '0;
    ch2_irq    = '0;
    ch3_irq    = '0;
    host_low   = 1'b0;
    repeat (3) @(negedge clk);
    #1 check(sirq_oe == 1'b0, "R1 in reset", {31'd0, sirq_oe}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    watch(4, seen);
    check(!seen, "R1 after reset", {31'd0, seen}, 32'd0);

    // continuous-mode table walk: R2 R3 R4 R5
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      ch1_irq = VEC[v][28:27];
      ch2_irq = VEC[v][26:22];
      ch3_irq = VEC[v][21:17];
      run_frame(3, mask, pok);
      check(mask == VEC[v][16:0], "R2/R3 slot mask", {15'd0, mask},
            {15'd0, VEC[v][16:0]});
      check(pok, "R4 slot phases", {31'd0, pok}, 32'd1);
    end

    // R6: continuous mode never drives while idle
    watch(12, seen);
    check(!seen, "R6 continuous idle", {31'd0, seen}, 32'd0);

    // R10: 3-clock low run opens no frame
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); host_low = 1'b1;
    end
    @(negedge clk); host_low = 1'b0;
    watch(12, seen);
    check(!seen, "R10 short start", {31'd0, seen}, 32'd0);

    // clear shown picture, then go quiet
    @(negedge clk); ch1_irq = '0; ch2_irq = '0; ch3_irq = '0;
    run_frame(3, mask, pok);
    check(mask == 17'h0, "R3 cleared", {15'd0, mask}, 32'd0);
    @(negedge clk); quiet_mode = 1'b1;
    watch(6, seen);
    check(!seen, "R8 quiet unchanged", {31'd0, seen}, 32'd0);

    // R7: new request makes one-clock low pulse
    @(negedge clk); ch2_irq = 5'b00010;
    @(negedge clk); #1;
    check(sirq_oe && !sirq_out, "R7 request pulse", {30'd0, sirq_oe, sirq_out}, 32'h2);
    @(negedge clk); #1;
    check(!sirq_oe, "R7 pulse one clock", {31'd0, sirq_oe}, 32'd0);
    run_frame(2, mask, pok);
    check(mask == 17'h00040, "R3 quiet IRQ6", {15'd0, mask}, 32'h40);
    watch(8, seen);
    check(!seen, "R8 shown already", {31'd0, seen}, 32'd0);

    // R7 on a cleared request; also shows a 2-clock quiet stop was accepted (R9)
    @(negedge clk); ch2_irq = '0;
    @(negedge clk); #1;
    check(sirq_oe && !sirq_out, "R7/R9 clear pulse", {30'd0, sirq_oe, sirq_out}, 32'h2);
    run_frame(2, mask, pok);
    check(mask == 17'h0, "R7 cleared frame", {15'd0, mask}, 32'd0);

    // R9: continuous mode rejects a 2-clock stop
    @(negedge clk); quiet_mode = 1'b0; ch1_irq = 2'b01;
    run_frame(2, mask, pok);
    check(mask == 17'h00002, "R2 IRQ1", {15'd0, mask}, 32'h2);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); host_low = 1'b1;
    end
    @(negedge clk); host_low = 1'b0;
    watch(60, seen);
    check(!seen, "R9 short stop held", {31'd0, seen}, 32'd0);
    run_frame(3, mask, pok);
    check(mask == 17'h00002 && pok, "R9 recovered", {15'd0, mask}, 32'h2);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule